// File: doc/BRIEF.md
# Complementary PWM Channel with Deadtime

This block is a single motor-drive PWM channel. A 32-bit timer counter is compared against two programmable values: a period value (Limit) and a pulse-width value (Match). Each comparison event moves one of two complementary outputs, A and B, to its passive level and moves the other to its active level. The rising output can be delayed by a programmable deadtime, so that both outputs are never active together. The channel counts either in edge-aligned form (up, then wrap to 0) or in center-aligned form (up to Limit, then back down to 0).

Both values are double-buffered. Software writes a write copy. The comparison uses an operating copy. While the channel is stopped, the operating copy follows the write copy. While it runs, the operating copy takes the write copy only at a period boundary, and a freeze control can hold that transfer off until the channel stops. Reads return the operating copy. A polarity input selects which level counts as passive.

Top module: `dtpwm_channel`

## Requirements
- R1: After reset, the operating copies of Limit and Match both read 0xFFFFFFFF, the counter reads 0, and both outputs sit at the passive level.
- R2: While `run` is low, the counter is held at 0 and both outputs are passive. A register write (`wrSel` 0 = Limit, 1 = Match) is visible on `rdData` from the edge that captures it.
- R3: In edge-aligned mode (`centerMode` low) with `run` high, the counter advances by one per cycle from 0. On the edge after it equals the operating Limit, it returns to 0, which gives a period of Limit+1 cycles.
- R4: In edge-aligned mode with `deadEn` low, the counter equalling Match makes B passive and A active at the next edge. The counter equalling Limit makes A passive and B active at the next edge.
- R5: With `deadEn` high, the output that is turning passive changes at the same edge as without deadtime. The other output turns active `deadVal` edges later; a `deadVal` of 0 acts as 1.
- R6: A Match value equal to or greater than the operating Limit has no effect on the outputs.
- R7: In center-aligned mode, the counter rises from 0 to Limit and then falls back to 0. Equality with Match while rising makes B passive and A active. Equality with Match while falling makes A passive and B active. Equality with Limit does not change either output.
- R8: While running with `holdUpdate` low, the operating copies take the write copies at the edge where the counter equals Limit (edge-aligned) or where it reaches 0 while falling (center-aligned). Until then, `rdData` (`rdSel` 0 = Limit, 1 = Match) shows the old operating value.
- R9: While running with `holdUpdate` high, the operating copies keep their values. They take the write copies at the first edge after `run` goes low.
- R10: `passiveLevel` selects the passive output level, and the active level is its inverse.
- R11: Outputs A and B are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channel runs while high |
| centerMode | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| deadEn | input | 1 | Enables deadtime before the rising output |
| holdUpdate | input | 1 | Freezes operating copies while running |
| passiveLevel | input | 1 | Output level in the passive state |
| deadVal | input | DT_W | Deadtime length in cycles |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 Limit, 1 Match |
| wrData | input | CNT_W | Write data |
| rdSel | input | 1 | Read source: 0 Limit, 1 Match (operating copies) |
| rdData | output | CNT_W | Operating value selected by rdSel |
| tcOut | output | CNT_W | Current counter value |
| outA | output | 1 | Output A |
| outB | output | 1 | Output B |

## Verification
The assertions assume that Match stays below Limit whenever output timing is being checked, and that the mode and deadtime controls change only while the channel is stopped. The bench follows both rules: it reprograms values and modes only with `run` low, and while running it writes only into the write copies, to test when those copies transfer. The deadtime check assumes a deadtime that is shorter than the gap to the next comparison event. The stimulus uses a deadtime of 3 cycles against Match-to-Limit gaps of at least 5 cycles.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
  typedef struct packed {
    logic limHit;
    logic matHit;
    logic zeroHit;
    logic limZero;
  } pwmStat_t;

  typedef struct packed {
    logic clear;
    logic stepUp;
    logic stepDown;
    logic reload;
  } pwmStrobe_t;
endpackage

// File: rtl/pwmch_datapath.sv
module pwmch_datapath
  import pwmch_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  input  pwmStrobe_t       strb,
  output pwmStat_t         stat,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] tc
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] limWr, limOp, matWr, matOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limWr <= ALL_ONES;
      limOp <= ALL_ONES;
      matWr <= ALL_ONES;
      matOp <= ALL_ONES;
    end else begin
      if (wrEn) begin
        if (wrSel) matWr <= wrData;
        else       limWr <= wrData;
      end
      if (!run) begin
        limOp <= (wrEn && !wrSel) ? wrData : limWr;
        matOp <= (wrEn &&  wrSel) ? wrData : matWr;
      end else if (strb.reload) begin
        limOp <= limWr;
        matOp <= matWr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tc <= '0;
    else if (strb.clear)    tc <= '0;
    else if (strb.stepUp)   tc <= tc + 1'b1;
    else if (strb.stepDown) tc <= tc - 1'b1;
  end

  always_comb begin
    stat.limHit  = (tc == limOp);
    stat.matHit  = (tc == matOp) && (matOp < limOp);
    stat.zeroHit = (tc == '0);
    stat.limZero = (limOp == '0);
  end

  assign rdData = rdSel ? matOp : limOp;

  // R3: while running the counter never passes the operating period
  p_tc_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (tc <= limOp));

  // R8: operating copies move only on a reload strobe while running
  p_op_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (run && !strb.reload) |=> ($stable(limOp) && $stable(matOp)));
endmodule

// File: rtl/pwmch_ctrl.sv
module pwmch_ctrl
  import pwmch_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  logic            centerMode,
  input  logic            deadEn,
  input  logic            holdUpdate,
  input  logic [DT_W-1:0] deadVal,
  input  pwmStat_t        stat,
  output pwmStrobe_t      strb,
  output logic            aAct,
  output logic            bAct
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic goingUp, pendA, pendB;
  logic [DT_W-1:0] dtCnt;
  logic evToA, evToB;

  always_comb begin
    strb = '0;
    if (!run) begin
      strb.clear = 1'b1;
    end else if (!centerMode) begin
      if (stat.limHit) strb.clear = 1'b1;
      else             strb.stepUp = 1'b1;
      strb.reload = stat.limHit && !holdUpdate;
    end else if (goingUp) begin
      if (stat.limZero)     strb = '0;
      else if (stat.limHit) strb.stepDown = 1'b1;
      else                  strb.stepUp = 1'b1;
    end else if (stat.zeroHit) begin
      strb.stepUp = 1'b1;
      strb.reload = !holdUpdate;
    end else begin
      strb.stepDown = 1'b1;
    end
  end

  assign evToA = run && stat.matHit && (!centerMode || goingUp);
  assign evToB = run && ((!centerMode && stat.limHit) ||
                         (centerMode && stat.matHit && !goingUp));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goingUp <= 1'b1;
      aAct    <= 1'b0;
      bAct    <= 1'b0;
      pendA   <= 1'b0;
      pendB   <= 1'b0;
      dtCnt   <= '0;
    end else if (!run) begin
      goingUp <= 1'b1;
      aAct    <= 1'b0;
      bAct    <= 1'b0;
      pendA   <= 1'b0;
      pendB   <= 1'b0;
    end else begin
      if (!centerMode)                                    goingUp <= 1'b1;
      else if (goingUp && stat.limHit && !stat.limZero)   goingUp <= 1'b0;
      else if (!goingUp && stat.zeroHit)                  goingUp <= 1'b1;

      if (evToA) begin
        bAct  <= 1'b0;
        pendB <= 1'b0;
        if (deadEn) begin
          pendA <= 1'b1;
          dtCnt <= deadVal;
        end else begin
          aAct  <= 1'b1;
          pendA <= 1'b0;
        end
      end else if (evToB) begin
        aAct  <= 1'b0;
        pendA <= 1'b0;
        if (deadEn) begin
          pendB <= 1'b1;
          dtCnt <= deadVal;
        end else begin
          bAct  <= 1'b1;
          pendB <= 1'b0;
        end
      end else if (pendA || pendB) begin
        if (dtCnt <= ONE) begin
          aAct  <= aAct | pendA;
          bAct  <= bAct | pendB;
          pendA <= 1'b0;
          pendB <= 1'b0;
        end else begin
          dtCnt <= dtCnt - ONE;
        end
      end
    end
  end

  // R11: complementary outputs never overlap
  p_never_both_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(aAct && bAct));

  // R2: stopping parks both outputs passive
  p_stop_passive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!aAct && !bAct));

  // R4: without deadtime the period edge swaps the outputs at once
  p_nodead_swap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (run && !deadEn && !centerMode && stat.limHit) |=> (bAct && !aAct));

  // R5: with deadtime the rising output waits after the period edge
  p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (run && deadEn && !centerMode && stat.limHit && (deadVal > ONE)) |=> !bAct);

  // R7: in center mode the period value leaves the outputs alone
  p_center_lim_r7: assert property (@(posedge clk) disable iff (!rstN)
    (run && centerMode && stat.limHit && !pendA && !pendB) |=>
      ($stable(aAct) && $stable(bAct)));
endmodule

// File: rtl/dtpwm_channel.sv
module dtpwm_channel
  import pwmch_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             centerMode,
  input  logic             deadEn,
  input  logic             holdUpdate,
  input  logic             passiveLevel,
  input  logic [DT_W-1:0]  deadVal,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] tcOut,
  output logic             outA,
  output logic             outB
);
  pwmStat_t   stat;
  pwmStrobe_t strb;
  logic       aAct, bAct;

  pwmch_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .run(run),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel),
    .strb(strb), .stat(stat), .rdData(rdData), .tc(tcOut)
  );

  pwmch_ctrl #(.DT_W(DT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .centerMode(centerMode),
    .deadEn(deadEn), .holdUpdate(holdUpdate), .deadVal(deadVal),
    .stat(stat), .strb(strb), .aAct(aAct), .bAct(bAct)
  );

  assign outA = passiveLevel ^ aAct;
  assign outB = passiveLevel ^ bAct;
endmodule

// File: tb/dtpwm_channel_tb.sv
module dtpwm_channel_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic run = 0, centerMode = 0, deadEn = 0, holdUpdate = 0, passiveLevel = 0;
  logic [7:0] deadVal = 8'd0;
  logic wrEn = 0, wrSel = 0, rdSel = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, tcOut;
  logic outA, outB;

  dtpwm_channel u_dut (
    .clk(clk), .rstN(rstN), .run(run), .centerMode(centerMode),
    .deadEn(deadEn), .holdUpdate(holdUpdate), .passiveLevel(passiveLevel),
    .deadVal(deadVal), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .tcOut(tcOut), .outA(outA), .outB(outB)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    int          at;
    int          kind;   // 0 outputs {A,B}, 1 Limit read, 2 Match read, 3 counter
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0, checks = 0, fails = 0, overlaps = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int at, int kind, logic [31:0] v, string tag);
    item_t it;
    it.at = at; it.kind = kind; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: pop every item due this cycle and compare
  always @(negedge clk) begin
    if (rstN && (outA != passiveLevel) && (outB != passiveLevel)) overlaps++;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at <= cyc) begin
        logic [31:0] act;
        case (sb[i].kind)
          0: act = {30'd0, outA, outB};
          1: begin rdSel = 1'b0; #1; act = rdData; end
          2: begin rdSel = 1'b1; #1; act = rdData; end
          default: act = tcOut;
        endcase
        checks++;
        if (sb[i].at != cyc || act != sb[i].exp) begin
          fails++;
          $display("FAIL %s cycle %0d kind %0d: actual %0h expected %0h",
                   sb[i].tag, sb[i].at, sb[i].kind, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_reg(logic sel, logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic wait_done();
    while (sb.size() != 0) @(negedge clk);
    tick(1);
  endtask

  task automatic stop_chan();
    run = 1'b0;
    tick(2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    s = cyc;
    expect_at(s, 1, 32'hFFFF_FFFF, "R1");
    expect_at(s, 2, 32'hFFFF_FFFF, "R1");
    expect_at(s, 0, 32'd0, "R1");
    expect_at(s, 3, 32'd0, "R1");
    wait_done();

    // R2 stopped writes reach the operating copy
    write_reg(1'b0, 32'd9); expect_at(cyc, 1, 32'd9, "R2");
    write_reg(1'b1, 32'd4); expect_at(cyc, 2, 32'd4, "R2");
    wait_done();

    // R3 R4 R8 edge-aligned, with a period change mid-run
    run = 1'b1; s = cyc;
    expect_at(s + 4, 3, 32'd4, "R3");
    expect_at(s + 4, 0, 32'b00, "R4");
    expect_at(s + 5, 0, 32'b10, "R4");
    expect_at(s + 9, 3, 32'd9, "R3");
    expect_at(s + 10, 3, 32'd0, "R3");
    expect_at(s + 10, 0, 32'b01, "R4");
    expect_at(s + 15, 0, 32'b10, "R4");
    tick(2);
    write_reg(1'b0, 32'd5);
    expect_at(s + 5, 1, 32'd9, "R8");
    expect_at(s + 11, 1, 32'd5, "R8");
    expect_at(s + 16, 0, 32'b01, "R8");
    wait_done();
    run = 1'b0; tick(1);
    expect_at(cyc, 0, 32'b00, "R2");
    expect_at(cyc, 3, 32'd0, "R2");
    wait_done();
    write_reg(1'b0, 32'd9);

    // R5 deadtime of 3 cycles
    deadEn = 1'b1; deadVal = 8'd3; tick(1);
    run = 1'b1; s = cyc;
    expect_at(s + 5, 0, 32'b00, "R5");
    expect_at(s + 7, 0, 32'b00, "R5");
    expect_at(s + 8, 0, 32'b10, "R5");
    expect_at(s + 10, 0, 32'b00, "R5");
    expect_at(s + 12, 0, 32'b00, "R5");
    expect_at(s + 13, 0, 32'b01, "R5");
    expect_at(s + 15, 0, 32'b00, "R5");
    expect_at(s + 18, 0, 32'b10, "R5");
    wait_done();
    stop_chan();
    deadEn = 1'b0; deadVal = 8'd0;

    // R10 inverted polarity
    passiveLevel = 1'b1; tick(1);
    expect_at(cyc, 0, 32'b11, "R10");
    run = 1'b1; s = cyc;
    expect_at(s + 4, 0, 32'b11, "R10");
    expect_at(s + 5, 0, 32'b01, "R10");
    expect_at(s + 10, 0, 32'b10, "R10");
    wait_done();
    stop_chan();
    passiveLevel = 1'b0;

    // R6 Match not below Limit
    write_reg(1'b1, 32'd12);
    run = 1'b1; s = cyc;
    expect_at(s + 8, 0, 32'b00, "R6");
    expect_at(s + 10, 0, 32'b01, "R6");
    expect_at(s + 19, 0, 32'b01, "R6");
    expect_at(s + 20, 0, 32'b01, "R6");
    wait_done();
    stop_chan();
    write_reg(1'b1, 32'd4);

    // R9 frozen update
    holdUpdate = 1'b1;
    run = 1'b1; s = cyc;
    tick(2);
    write_reg(1'b0, 32'd5);
    expect_at(s + 11, 1, 32'd9, "R9");
    expect_at(s + 16, 0, 32'b10, "R9");
    expect_at(s + 20, 0, 32'b01, "R9");
    wait_done();
    run = 1'b0; tick(1);
    expect_at(cyc, 1, 32'd5, "R9");
    wait_done();
    holdUpdate = 1'b0;

    // R7 R8 center-aligned
    write_reg(1'b0, 32'd6);
    write_reg(1'b1, 32'd2);
    centerMode = 1'b1; tick(1);
    run = 1'b1; s = cyc;
    expect_at(s + 3, 0, 32'b10, "R7");
    expect_at(s + 6, 3, 32'd6, "R7");
    expect_at(s + 7, 3, 32'd5, "R7");
    expect_at(s + 7, 0, 32'b10, "R7");
    expect_at(s + 10, 0, 32'b10, "R7");
    expect_at(s + 11, 0, 32'b01, "R7");
    expect_at(s + 12, 3, 32'd0, "R7");
    expect_at(s + 13, 3, 32'd1, "R7");
    expect_at(s + 14, 0, 32'b01, "R7");
    expect_at(s + 15, 0, 32'b10, "R7");
    tick(1);
    write_reg(1'b0, 32'd4);
    expect_at(s + 7, 1, 32'd6, "R8");
    expect_at(s + 13, 1, 32'd4, "R8");
    wait_done();
    stop_chan();
    centerMode = 1'b0;

    // R11 no overlap seen on any sampled cycle
    checks++;
    if (overlaps != 0) begin
      fails++;
      $display("FAIL R11: actual %0d overlap cycles expected 0", overlaps);
    end
    finish_run();
  end
endmodule